// File: doc/BRIEF.md
# Page-Commit Busy Controller

This block sits between the byte-level front end of a two-wire serial slave and a page-organised non-volatile store. The front end passes it one-cycle event strobes: a START or STOP was seen, the slave address matched (with its read/write bit), the memory address byte arrived, a data byte arrived, or the host has clocked out a read byte. For writes, the controller gathers data bytes into a page buffer. It loads that buffer from the store when the first byte arrives, so bytes the host does not touch keep their old values. It also records which page is targeted.

When a write transaction ends with STOP, the controller commits the whole page back to the store. This takes a fixed number of clock cycles. During that time `busy` is high, and every address attempt is refused so that the front end sends NACK. A host can therefore poll with repeated address bytes. The first acknowledged attempt tells it the commit has finished. Reads come from the store at an internal pointer that advances byte by byte across the whole address space.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy`, `addrAck` and `memWrEn` are all low.
- R2: An `evAddr` strobe that follows START while `busy` is low gives `addrAck` high for exactly the next cycle, for both values of `addrRead` (1 = read, 0 = write).
- R3: A STOP that follows at least one data byte raises `busy` in the next cycle. `busy` then stays high for exactly COMMIT_CYCLES cycles.
- R4: While `busy` is high, `addrAck` stays low for every `evAddr`, for reads and writes. Any memory address, data or STOP strobes seen during the commit have no effect on the store and start no second commit. All events up to the next START are ignored.
- R5: A commit writes all PAGE_BYTES bytes of the target page. Bytes that were not written in the transaction keep their previous contents.
- R6: The write offset wraps within the target page. Bytes past the last byte of the page land at offset 0 onward of the same page, and the page index never changes.
- R7: A STOP that comes after the memory address byte but before any data byte starts no commit. `busy` stays low.
- R8: In a read transaction, `rdData` shows the stored byte at the pointer, and each `evRdNext` advances the pointer by one. The pointer crosses page boundaries and wraps from the top address to 0.
- R9: A START that arrives while data bytes are gathered but before STOP discards them. No commit happens and the store is unchanged.
- R10: `memWrEn` is high for exactly one cycle per commit, in the last cycle that `busy` is high. `memWrData` then carries the full page buffer for the page at `memWrPage`.
- R11: The first address attempt after `busy` falls is acknowledged. The data read back then reflects the committed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evStart | input | 1 | START condition seen (one-cycle strobe) |
| evStop | input | 1 | STOP condition seen (one-cycle strobe) |
| evAddr | input | 1 | Own slave address byte received (one-cycle strobe) |
| addrRead | input | 1 | Read/write bit of that address byte, 1 = read |
| evMemAddr | input | 1 | Memory address byte received |
| memAddr | input | ADDR_W | Memory address value |
| evData | input | 1 | Write data byte received |
| wrByte | input | 8 | Write data value |
| evRdNext | input | 1 | Host took the current read byte; advance the pointer |
| addrAck | output | 1 | Acknowledge for the address byte, valid the cycle after `evAddr` |
| busy | output | 1 | Commit in progress; the front end sends NACK for its address |
| rdData | output | 8 | Stored byte at the pointer |
| memRdPage | output | ADDR_W-log2(PAGE_BYTES) | Page index read from the store |
| memRdData | input | 8*PAGE_BYTES | Contents of page `memRdPage`, byte 0 in the low bits |
| memWrEn | output | 1 | Page write strobe to the store |
| memWrPage | output | ADDR_W-log2(PAGE_BYTES) | Page index being written |
| memWrData | output | 8*PAGE_BYTES | Page contents being written, byte 0 in the low bits |

## Verification
The hardest situation to reach is a full, well-formed host transaction landing inside the commit window: START, address attempts of both directions, a memory address, a data byte and a STOP, all while `busy` is high. The bench sends that sequence straight after the STOP that began a commit, with one event per cycle, so the whole burst fits inside the window. It then waits for `busy` to fall and polls once. The read back must show the stray byte absent and the committed page intact.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ADDR,
    ST_WAIT_MEM,
    ST_MEM_SET,
    ST_COLLECT,
    ST_READ,
    ST_COMMIT
  } pccState_t;

  typedef struct packed {
    logic loadPtr;
    logic firstByte;
    logic nextByte;
    logic readStep;
    logic commit;
  } pccStrobe_t;

endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int COMMIT_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       evAddr,
  input  logic       addrRead,
  input  logic       evMemAddr,
  input  logic       evData,
  input  logic       evRdNext,
  output pccStrobe_t stb,
  output logic       busy,
  output logic       addrAck
);

  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES - 1);

  pccState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             ackNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    ackNext   = 1'b0;
    if (state == ST_COMMIT) begin
      if (waitCnt == '0) begin
        stb.commit = 1'b1;
        stateNext  = ST_IDLE;
      end
    end else if (evStart) begin
      stateNext = ST_WAIT_ADDR;
    end else begin
      unique case (state)
        ST_WAIT_ADDR: begin
          if (evAddr) begin
            ackNext   = 1'b1;
            stateNext = addrRead ? ST_READ : ST_WAIT_MEM;
          end else if (evStop) begin
            stateNext = ST_IDLE;
          end
        end
        ST_WAIT_MEM: begin
          if (evMemAddr) begin
            stb.loadPtr = 1'b1;
            stateNext   = ST_MEM_SET;
          end else if (evStop) begin
            stateNext = ST_IDLE;
          end
        end
        ST_MEM_SET: begin
          if (evData) begin
            stb.firstByte = 1'b1;
            stateNext     = ST_COLLECT;
          end else if (evStop) begin
            stateNext = ST_IDLE;
          end
        end
        ST_COLLECT: begin
          if (evData) begin
            stb.nextByte = 1'b1;
          end else if (evStop) begin
            stateNext = ST_COMMIT;
          end
        end
        ST_READ: begin
          if (evRdNext) begin
            stb.readStep = 1'b1;
          end else if (evStop) begin
            stateNext = ST_IDLE;
          end
        end
        default: begin
          stateNext = state;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      addrAck <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state   <= stateNext;
      addrAck <= ackNext;
      busy    <= (stateNext == ST_COMMIT);
      if (state != ST_COMMIT && stateNext == ST_COMMIT) begin
        waitCnt <= CNT_LOAD;
      end else if (state == ST_COMMIT && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pccStrobe_t                        stb,
  input  logic [ADDR_W-1:0]                 memAddr,
  input  logic [7:0]                        wrByte,
  input  logic [8*PAGE_BYTES-1:0]           memRdData,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memRdPage,
  output logic [7:0]                        rdData,
  output logic                              memWrEn,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memWrPage,
  output logic [8*PAGE_BYTES-1:0]           memWrData
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0]             ptr;
  logic [OFS_W-1:0]              ptrOfs;
  logic [PAGE_W-1:0]             ptrPage;
  logic [PAGE_BYTES-1:0][7:0]    pageBuf;
  logic [PAGE_BYTES-1:0][7:0]    rdView;

  assign ptrOfs  = ptr[OFS_W-1:0];
  assign ptrPage = ptr[ADDR_W-1:OFS_W];
  assign rdView  = memRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= memAddr;
    end else if (stb.firstByte || stb.nextByte) begin
      ptr <= {ptrPage, ptrOfs + 1'b1};
    end else if (stb.readStep) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g] <= '0;
      end else if (stb.firstByte) begin
        pageBuf[g] <= (ptrOfs == OFS_W'(g)) ? wrByte : rdView[g];
      end else if (stb.nextByte && ptrOfs == OFS_W'(g)) begin
        pageBuf[g] <= wrByte;
      end
    end
  end

  assign memRdPage = ptrPage;
  assign rdData    = rdView[ptrOfs];
  assign memWrEn   = stb.commit;
  assign memWrPage = ptrPage;
  assign memWrData = pageBuf;

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int PAGE_BYTES    = 8,
  parameter int COMMIT_CYCLES = 40
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 evStart,
  input  logic                                 evStop,
  input  logic                                 evAddr,
  input  logic                                 addrRead,
  input  logic                                 evMemAddr,
  input  logic [ADDR_W-1:0]                    memAddr,
  input  logic                                 evData,
  input  logic [7:0]                           wrByte,
  input  logic                                 evRdNext,
  output logic                                 addrAck,
  output logic                                 busy,
  output logic [7:0]                           rdData,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memRdPage,
  input  logic [8*PAGE_BYTES-1:0]              memRdData,
  output logic                                 memWrEn,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] memWrPage,
  output logic [8*PAGE_BYTES-1:0]              memWrData
);

  pccStrobe_t stb;

  pcc_ctrl #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evStart   (evStart),
    .evStop    (evStop),
    .evAddr    (evAddr),
    .addrRead  (addrRead),
    .evMemAddr (evMemAddr),
    .evData    (evData),
    .evRdNext  (evRdNext),
    .stb       (stb),
    .busy      (busy),
    .addrAck   (addrAck)
  );

  pcc_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .memAddr   (memAddr),
    .wrByte    (wrByte),
    .memRdData (memRdData),
    .memRdPage (memRdPage),
    .rdData    (rdData),
    .memWrEn   (memWrEn),
    .memWrPage (memWrPage),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int COMMIT_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic evStop,
  input logic evAddr,
  input logic addrAck,
  input logic busy,
  input logic memWrEn
);

  localparam int RUN_W = $clog2(COMMIT_CYCLES + 2) + 1;

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyRun <= '0;
    else if (busy)  busyRun <= busyRun + 1'b1;
    else            busyRun <= '0;
  end

  // R3: the busy window is exactly COMMIT_CYCLES long
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == RUN_W'(COMMIT_CYCLES));

  // R3: busy rises only right after a STOP
  a_r3_rise_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(evStop));

  // R4: no acknowledge while a commit is running
  a_r4_nack_busy: assert property (@(posedge clk) disable iff (!rstN)
    (evAddr && busy) |=> !addrAck);

  // R2: acknowledge only follows an address strobe
  a_r2_ack_needs_addr: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> $past(evAddr) && !$past(busy));

  // R10: page write happens in the last busy cycle
  a_r10_write_last: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy ##1 !busy);

endmodule

bind page_commit_ctrl pcc_checker #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_pcc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .evStop  (evStop),
  .evAddr  (evAddr),
  .addrAck (addrAck),
  .busy    (busy),
  .memWrEn (memWrEn)
);

// File: tb/test_page_commit_ctrl.sv
`timescale 1ns/1ps
module test_page_commit_ctrl;

  localparam int ADDR_W = 8;
  localparam int PB     = 8;
  localparam int CC     = 20;
  localparam int PAGES  = (1 << ADDR_W) / PB;
  localparam int PW     = ADDR_W - $clog2(PB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, evStop = 0, evAddr = 0, addrRead = 0;
  logic evMemAddr = 0, evData = 0, evRdNext = 0;
  logic [ADDR_W-1:0] memAddr = '0;
  logic [7:0] wrByte = '0;
  logic addrAck, busy, memWrEn;
  logic [7:0] rdData;
  logic [PW-1:0] memRdPage, memWrPage;
  logic [8*PB-1:0] memRdData, memWrData;

  logic [8*PB-1:0] store [PAGES];
  logic [7:0] model [1 << ADDR_W];
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign memRdData = store[memRdPage];
  always @(posedge clk) if (memWrEn) store[memWrPage] <= memWrData;

  page_commit_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .COMMIT_CYCLES(CC)) i_page_commit_ctrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop), .evAddr(evAddr),
    .addrRead(addrRead), .evMemAddr(evMemAddr), .memAddr(memAddr), .evData(evData),
    .wrByte(wrByte), .evRdNext(evRdNext), .addrAck(addrAck), .busy(busy),
    .rdData(rdData), .memRdPage(memRdPage), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrPage(memWrPage), .memWrData(memWrData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doStart(); evStart = 1; @(negedge clk); evStart = 0; endtask
  task automatic doStop();  evStop = 1;  @(negedge clk); evStop = 0;  endtask
  task automatic doRdNext(); evRdNext = 1; @(negedge clk); evRdNext = 0; endtask
  task automatic doMemAddr(input logic [7:0] a);
    memAddr = a; evMemAddr = 1; @(negedge clk); evMemAddr = 0;
  endtask
  task automatic doData(input logic [7:0] d);
    wrByte = d; evData = 1; @(negedge clk); evData = 0;
  endtask
  task automatic doAddr(input logic rd, output logic ack);
    addrRead = rd; evAddr = 1; @(negedge clk); ack = addrAck; evAddr = 0;
  endtask

  // watch a commit from the cycle after STOP; check length and write strobe
  task automatic watchCommit(input string req);
    int n = 0, wrCnt = 0, wrPos = -1;
    while (busy && n < 1000) begin
      if (memWrEn) begin wrCnt++; wrPos = n; end
      n++;
      @(negedge clk);
    end
    chk(n == CC, {req, " R3 busy length"}, n, CC);
    chk(wrCnt == 1 && wrPos == CC - 1, {req, " R10 write strobe in last busy cycle"}, wrPos, CC - 1);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic readCheck(input logic [7:0] a, input int cnt, input string req);
    logic ack;
    doStart(); doAddr(0, ack); doMemAddr(a); doStart(); doAddr(1, ack);
    chk(ack, {req, " read address ack"}, ack, 1);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] ea = a + 8'(i);
      chk(rdData == model[ea], {req, " read byte"}, rdData, model[ea]);
      doRdNext();
    end
    doStop();
  endtask

  task automatic writeTxn(input logic [7:0] a, input logic [7:0] d [], input string req);
    logic ack;
    logic [7:0] p;
    doStart(); doAddr(0, ack);
    chk(ack, {req, " R2 write address ack"}, ack, 1);
    doMemAddr(a);
    p = a;
    foreach (d[i]) begin
      doData(d[i]);
      model[p] = d[i];
      p = {p[7:3], p[2:0] + 3'd1};
    end
    doStop();
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(addrAck == 0, "R1 addrAck after reset", addrAck, 0);
    chk(memWrEn == 0, "R1 memWrEn after reset", memWrEn, 0);
  endtask

  task automatic t_singleByte();
    logic [7:0] d [] = '{8'hA7};
    writeTxn(8'h13, d, "R5");
    chk(busy == 1, "R3 busy right after stop", busy, 1);
    watchCommit("R5");
    readCheck(8'h10, 8, "R5 full page kept");
  endtask

  task automatic t_wrap();
    logic [7:0] d [] = '{8'h11, 8'h22, 8'h33};
    writeTxn(8'h0E, d, "R6");
    watchCommit("R6");
    readCheck(8'h08, 8, "R6 wrap in page");
    chk(model[8'h08] == 8'h33, "R6 model wrap", model[8'h08], 8'h33);
  endtask

  task automatic t_noData();
    logic ack;
    int seen = 0;
    doStart(); doAddr(0, ack); doMemAddr(8'h40); doStop();
    for (int i = 0; i < CC + 4; i++) begin
      if (busy || memWrEn) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R7 no commit without data", seen, 0);
  endtask

  task automatic t_restart();
    logic ack;
    int seen = 0;
    doStart(); doAddr(0, ack); doMemAddr(8'h50); doData(8'hC3); doData(8'h3C);
    doStart(); doStop();
    for (int i = 0; i < CC + 4; i++) begin
      if (busy || memWrEn) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 no commit after restart", seen, 0);
    readCheck(8'h50, 2, "R9 store unchanged");
  endtask

  task automatic t_busyPoll();
    logic [7:0] d [] = '{8'h5E, 8'h6F};
    logic ack;
    int seen = 0;
    writeTxn(8'h21, d, "R4");
    doStart(); doAddr(0, ack);
    chk(ack == 0, "R4 write address nack while busy", ack, 0);
    doAddr(1, ack);
    chk(ack == 0, "R4 read address nack while busy", ack, 0);
    doMemAddr(8'h22); doData(8'hEE); doStop();
    chk(busy == 1, "R4 still busy after stray burst", busy, 1);
    waitIdle();
    for (int i = 0; i < CC + 4; i++) begin
      if (busy || memWrEn) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R4 stray stop started no commit", seen, 0);
    doStart(); doAddr(0, ack);
    chk(ack == 1, "R11 first poll after commit acked", ack, 1);
    doStop();
    readCheck(8'h20, 8, "R11 committed page readable");
  endtask

  task automatic t_readCross();
    readCheck(8'h1D, 6, "R8 read across page");
    readCheck(8'hFE, 4, "R8 read wrap at top");
  endtask

  initial begin
    for (int p = 0; p < PAGES; p++)
      for (int i = 0; i < PB; i++) begin
        model[p*PB+i] = 8'(p*PB+i) ^ 8'h5A;
        store[p][i*8 +: 8] = 8'(p*PB+i) ^ 8'h5A;
      end
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_singleByte();
    t_wrap();
    t_noData();
    t_restart();
    t_busyPoll();
    t_readCross();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule